// File: doc/BRIEF.md
# Sobel Gradient Kernel Unit

This block produces a single Sobel gradient component from a 3×3 pixel neighbourhood. Six pixels arrive in parallel: three on the line weighted positively and three on the line weighted negatively. Within each line the two outer taps carry weight one and the centre tap carries weight two. The centre tap is doubled by a one-bit left shift, so the block has no multiplier. The result is the positive line sum minus the negative line sum. It is registered as a signed two's-complement value and appears one clock after a valid strobe, together with a ready flag.

The block has no notion of direction. The caller selects the gradient through its pixel routing. Take a row-major window with indices 0 to 8. For the horizontal gradient, the caller routes indices 2, 5 and 8 to the positive line and 0, 3 and 6 to the negative line. For the vertical gradient, it routes indices 0, 1 and 2 to the positive line and 6, 7 and 8 to the negative line. In both cases the middle index of each triple goes to the centre port. Two instances side by side therefore give both components in the same cycle.

Top module: `sobel_grad_kernel`

## Requirements
- R1: When `valid_i` is sampled high, `grad_o` on the next clock equals (pos_side0 + 2·pos_mid + pos_side1) − (neg_side0 + 2·neg_mid + neg_side1). All pixels are treated as unsigned and zero-extended, and the result is written as a RES_W-bit two's-complement value.
- R2: `ready_o` is high in the cycle that follows a rising clock edge at which `valid_i` was high.
- R3: `ready_o` is low in the cycle that follows a rising clock edge at which `valid_i` was low.
- R4: A clock edge with `valid_i` low leaves `grad_o` unchanged, whatever the pixel inputs carry.
- R5: While `rst_ni` is low, `ready_o` is 0 and `grad_o` is 0.
- R6: Full-scale inputs are exact. With all positive taps at 2^PIX_W−1 and all negative taps at 0, the result is +4·(2^PIX_W−1). With the lines swapped, the result is −4·(2^PIX_W−1).
- R7: Exchanging the positive and negative lines negates the result. With horizontal routing, a window whose right column is (9, 6, 8) and whose left column is (10, 0, 5) gives +14. Positive taps (4, 2, 4) against negative taps (9, 6, 9) give −18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel taps are valid this cycle |
| pos_side0_i | input | PIX_W | Positive line, first outer tap (weight 1) |
| pos_mid_i | input | PIX_W | Positive line, centre tap (weight 2) |
| pos_side1_i | input | PIX_W | Positive line, second outer tap (weight 1) |
| neg_side0_i | input | PIX_W | Negative line, first outer tap (weight 1) |
| neg_mid_i | input | PIX_W | Negative line, centre tap (weight 2) |
| neg_side1_i | input | PIX_W | Negative line, second outer tap (weight 1) |
| grad_o | output | RES_W | Registered signed gradient |
| ready_o | output | 1 | `grad_o` was updated by the previous edge |

## Verification
The assertions rely on a few assumptions about the inputs. `valid_i` and the six pixel taps are known at every post-reset clock edge. The pixels can take any unsigned value across their full width. The default widths leave RES_W large enough that the signed difference never wraps. The bench changes every input only on the falling clock edge and leaves no input undriven after reset. Random pixel values cover the whole 24-bit range, and the directed cases pin the all-ones and all-zero extremes.

// File: rtl/sobel_grad_pkg.sv
package sobel_grad_pkg;
  localparam int unsigned NUM_LINES     = 2;
  localparam int unsigned TAPS_PER_LINE = 3;
  localparam int unsigned LINE_POS      = 0;
  localparam int unsigned LINE_NEG      = 1;
  localparam int unsigned TAP_SIDE0     = 0;
  localparam int unsigned TAP_MID       = 1;
  localparam int unsigned TAP_SIDE1     = 2;
endpackage

// File: rtl/sgk_line_sum.sv
module sgk_line_sum #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned SUM_W = PIX_W + 2
) (
  input  logic [PIX_W-1:0] side0_i,
  input  logic [PIX_W-1:0] mid_i,
  input  logic [PIX_W-1:0] side1_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] side0_ext, mid_ext, side1_ext, mid_dbl;

  assign side0_ext = SUM_W'(side0_i);
  assign mid_ext   = SUM_W'(mid_i);
  assign side1_ext = SUM_W'(side1_i);
  // weight 2 on the centre tap: shift, no multiplier
  assign mid_dbl   = mid_ext << 1;
  assign sum_o     = side0_ext + mid_dbl + side1_ext;
endmodule

// File: rtl/sgk_diff.sv
module sgk_diff #(
  parameter int unsigned SUM_W = 26,
  parameter int unsigned RES_W = 29
) (
  input  logic [SUM_W-1:0] pos_i,
  input  logic [SUM_W-1:0] neg_i,
  output logic [RES_W-1:0] diff_o
);
  localparam int unsigned DIFF_W = SUM_W + 1;

  logic signed [DIFF_W-1:0] diff;

  // one guard bit keeps the unsigned difference exact
  assign diff = $signed({1'b0, pos_i}) - $signed({1'b0, neg_i});

  if (RES_W > DIFF_W) begin : g_sext
    assign diff_o = {{(RES_W-DIFF_W){diff[DIFF_W-1]}}, diff};
  end else if (RES_W == DIFF_W) begin : g_exact
    assign diff_o = diff;
  end else begin : g_trunc
    assign diff_o = diff[RES_W-1:0];
  end
endmodule

// File: rtl/sgk_out_reg.sv
module sgk_out_reg #(
  parameter int unsigned RES_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RES_W-1:0] grad_d_i,
  output logic [RES_W-1:0] grad_o,
  output logic             ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grad_o  <= '0;
      ready_o <= 1'b0;
    end else begin
      ready_o <= valid_i;
      if (valid_i) grad_o <= grad_d_i;
    end
  end
endmodule

// File: rtl/sobel_grad_kernel.sv
module sobel_grad_kernel
  import sobel_grad_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned RES_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] pos_side0_i,
  input  logic [PIX_W-1:0] pos_mid_i,
  input  logic [PIX_W-1:0] pos_side1_i,
  input  logic [PIX_W-1:0] neg_side0_i,
  input  logic [PIX_W-1:0] neg_mid_i,
  input  logic [PIX_W-1:0] neg_side1_i,
  output logic [RES_W-1:0] grad_o,
  output logic             ready_o
);
  localparam int unsigned SUM_W = PIX_W + 2;

  logic [PIX_W-1:0] taps     [NUM_LINES][TAPS_PER_LINE];
  logic [SUM_W-1:0] line_sum [NUM_LINES];
  logic [RES_W-1:0] grad_d;

  assign taps[LINE_POS][TAP_SIDE0] = pos_side0_i;
  assign taps[LINE_POS][TAP_MID]   = pos_mid_i;
  assign taps[LINE_POS][TAP_SIDE1] = pos_side1_i;
  assign taps[LINE_NEG][TAP_SIDE0] = neg_side0_i;
  assign taps[LINE_NEG][TAP_MID]   = neg_mid_i;
  assign taps[LINE_NEG][TAP_SIDE1] = neg_side1_i;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    sgk_line_sum #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_line_sum (
      .side0_i(taps[l][TAP_SIDE0]),
      .mid_i  (taps[l][TAP_MID]),
      .side1_i(taps[l][TAP_SIDE1]),
      .sum_o  (line_sum[l])
    );
  end

  sgk_diff #(.SUM_W(SUM_W), .RES_W(RES_W)) u_diff (
    .pos_i (line_sum[LINE_POS]),
    .neg_i (line_sum[LINE_NEG]),
    .diff_o(grad_d)
  );

  sgk_out_reg #(.RES_W(RES_W)) u_out_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .grad_d_i(grad_d),
    .grad_o  (grad_o),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/sobel_grad_kernel_chk.sv
module sobel_grad_kernel_chk #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned RES_W = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [PIX_W-1:0] pos_side0_i,
  input logic [PIX_W-1:0] pos_mid_i,
  input logic [PIX_W-1:0] pos_side1_i,
  input logic [PIX_W-1:0] neg_side0_i,
  input logic [PIX_W-1:0] neg_mid_i,
  input logic [PIX_W-1:0] neg_side1_i,
  input logic [RES_W-1:0] grad_o,
  input logic             ready_o
);
  logic signed [63:0] ref_full;
  logic [RES_W-1:0]   ref_res;

  assign ref_full = 64'(pos_side0_i) + 64'(pos_mid_i) * 64'sd2 + 64'(pos_side1_i)
                  - 64'(neg_side0_i) - 64'(neg_mid_i) * 64'sd2 - 64'(neg_side1_i);
  assign ref_res  = ref_full[RES_W-1:0];

  p_result_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> grad_o == $past(ref_res));

  p_ready_after_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ready_o);

  p_ready_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !ready_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(grad_o));
endmodule

bind sobel_grad_kernel sobel_grad_kernel_chk #(.PIX_W(PIX_W), .RES_W(RES_W)) u_chk (.*);

// File: tb/sobel_grad_kernel_bench.sv
module sobel_grad_kernel_bench;
  localparam int unsigned PIX_W = 24;
  localparam int unsigned RES_W = 29;
  localparam longint      PMAX  = (64'd1 << PIX_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic [PIX_W-1:0] ps0 = '0, pm = '0, ps1 = '0, ns0 = '0, nm = '0, ns1 = '0;
  logic [RES_W-1:0] grad;
  logic             ready;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  sobel_grad_kernel #(.PIX_W(PIX_W), .RES_W(RES_W)) u_sobel_grad_kernel (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .pos_side0_i(ps0), .pos_mid_i(pm), .pos_side1_i(ps1),
    .neg_side0_i(ns0), .neg_mid_i(nm), .neg_side1_i(ns1),
    .grad_o(grad), .ready_o(ready)
  );

  function automatic logic [RES_W-1:0] ref_grad(longint a, longint b, longint c,
                                                longint d, longint e, longint f);
    longint r;
    r = (a + 2*b + c) - (d + 2*e + f);
    return r[RES_W-1:0];
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // drive at falling edge, result is visible at the following falling edge
  task automatic drive(logic v, longint a, longint b, longint c,
                       longint d, longint e, longint f);
    valid = v;
    ps0 = a[PIX_W-1:0]; pm = b[PIX_W-1:0]; ps1 = c[PIX_W-1:0];
    ns0 = d[PIX_W-1:0]; nm = e[PIX_W-1:0]; ns1 = f[PIX_W-1:0];
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [RES_W-1:0] held;
    logic [RES_W-1:0] exp_g;
    logic [RES_W-1:0] window [9];
    longint v [6];
    void'($urandom(32'd4242));

    @(negedge clk);
    drive(1'b1, 5, 5, 5, 1, 1, 1);
    chk("R5 ready in reset", ready, 0);
    chk("R5 grad in reset", grad, 0);
    rst_n = 1'b1;
    drive(1'b0, 0, 0, 0, 0, 0, 0);
    chk("R3 ready idle after reset", ready, 0);

    // window laid out row-major; horizontal gradient: right column minus left column
    window[0] = 10; window[1] = 1; window[2] = 9;
    window[3] = 0;  window[4] = 7; window[5] = 6;
    window[6] = 5;  window[7] = 3; window[8] = 8;
    drive(1'b1, window[2], window[5], window[8], window[0], window[3], window[6]);
    chk("R7 horizontal sample", $signed(grad), 14);
    chk("R2 ready after valid", ready, 1);

    drive(1'b1, 4, 2, 4, 9, 6, 9);
    chk("R7 sample negative", $signed(grad), -18);
    drive(1'b1, 9, 6, 9, 4, 2, 4);
    chk("R7 swapped lines negate", $signed(grad), 18);

    drive(1'b1, PMAX, PMAX, PMAX, 0, 0, 0);
    chk("R6 full scale positive", $signed(grad), 4*PMAX);
    drive(1'b1, 0, 0, 0, PMAX, PMAX, PMAX);
    chk("R6 full scale negative", $signed(grad), -4*PMAX);
    held = grad;

    drive(1'b0, PMAX, 1, 2, 3, 4, 5);
    chk("R3 ready drops", ready, 0);
    chk("R4 grad held", grad, held);
    drive(1'b0, 7, 7, 7, 0, 0, 0);
    chk("R4 grad still held", grad, held);

    drive(1'b1, PMAX, 0, PMAX, PMAX, 0, PMAX);
    chk("R1 balanced lines", grad, 0);

    held = grad;
    for (int i = 0; i < 300; i++) begin
      logic vb;
      vb = ($urandom % 4) != 0;
      for (int k = 0; k < 6; k++) v[k] = longint'($urandom) & PMAX;
      if (i % 17 == 0) for (int k = 0; k < 3; k++) v[k] = PMAX;
      exp_g = vb ? ref_grad(v[0], v[1], v[2], v[3], v[4], v[5]) : held;
      drive(vb, v[0], v[1], v[2], v[3], v[4], v[5]);
      chk(vb ? "R1 random result" : "R4 random hold", grad, exp_g);
      chk(vb ? "R2 random ready" : "R3 random ready", ready, vb);
      held = exp_g;
    end

    rst_n = 1'b0;
    #1;
    chk("R5 async reset ready", ready, 0);
    chk("R5 async reset grad", grad, 0);
    finish_run();
  end
endmodule